// File: doc/BRIEF.md
# Daisy-Chainable Serial Result Shifter

This block is the converter-side serial output of a successive-approximation data converter, modelled as synchronous logic. When the converter reports a finished conversion, the parallel result word is placed into a shift register. A host then clocks the word out, most significant bit first, on its own serial clock. That clock has effect only while the active-low chip select and read enable are both asserted, and only while the conversion-busy flag is low.

A serial data input lets several converters share one data line. Each falling serial-clock edge shifts the register and pushes a bit in at its least significant end. That bit is captured from the cascade input on the preceding rising edge. The word of the converter upstream therefore follows the local least significant bit with no gap.

The serial pins are brought into the system clock domain through a synchronizer chain. Serial-clock edges are found by comparing each synchronized sample with the one before it. This works with a continuous or a gated serial clock, whether it idles high or low.

Top module: `result_chain_tx`

## Requirements
- R1: After reset the shift register holds all zeros, so a selected device with no loaded result drives 0, and a deselected device drives the idle level.
- R2: A one-cycle `conv_done` pulse loads `conv_result` into the shift register on the next clock when no read is in progress.
- R3: While selected, `sdout` shows the register MSB. Each falling `sclk` edge shifts the register one place toward the MSB, so after k falling edges `sdout` shows result bit WIDTH-1-k.
- R4: `sclk` edges have no effect while `cs_n` or `rd_n` is high. The stored word is read intact afterwards.
- R5: `sclk` edges have no effect while `busy` is high.
- R6: `sdin` is captured on each rising `sclk` edge and enters at the LSB on the next falling edge. In a two-device chain the host reads the local word, then the upstream word, over 2*WIDTH rising edges.
- R7: While `cs_n` or `rd_n` is high, `sdout` equals the parameter IDLE_LEVEL.
- R8: A `conv_done` pulse during a read is ignored. A read is in progress while selected once at least one falling edge has been accepted. The read in progress continues with the old word.
- R9: The `sclk` level present when the device is selected is not an edge. With `sclk` already high at selection, `sdout` keeps the MSB until the first falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle pulse: conversion finished |
| conv_result | input | WIDTH | Parallel conversion result |
| busy | input | 1 | Conversion in progress; serial clock ignored while high |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read enable |
| sclk | input | 1 | External serial clock |
| sdin | input | 1 | Cascade data input from the upstream device |
| sdout | output | 1 | Serial data output |

## Verification
The bench builds two instances with WIDTH = 5, SYNC_STAGES = 2 and IDLE_LEVEL = 1, and cascades them. The upstream device feeds the downstream cascade input. The narrow word lets all 32 local values be swept through full 11-bit chain reads, each paired with a different upstream word. The idle level of 1 tells the deselected state apart from an empty register. The gating, busy, reload-during-read and high-idle-clock cases are each run on this small configuration, with expected bit streams computed by concatenation in the bench.

// File: rtl/rct_pkg.sv
package rct_pkg;

  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic busy;
    logic sclk;
    logic sdin;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, busy: 1'b0,
                                  sclk: 1'b0, sdin: 1'b0};

  function automatic logic selected(pins_t p);
    return !p.cs_n && !p.rd_n;
  endfunction

  function automatic logic clock_open(pins_t p);
    return selected(p) && !p.busy;
  endfunction

endpackage

// File: rtl/rct_pin_sync.sv
module rct_pin_sync
  import rct_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t raw,
  output pins_t synced
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    pins_t q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= PINS_IDLE;
        else        q <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= PINS_IDLE;
        else        q <= g_stage[g-1].q;
      end
    end
  end

  assign synced = g_stage[STAGES-1].q;

endmodule

// File: rtl/rct_edge_gate.sv
module rct_edge_gate
  import rct_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t pin,
  output logic  sel,
  output logic  rise_evt,
  output logic  fall_evt
);

  logic sclk_prev;
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= pin.sclk;
  end

  always_comb begin
    sel      = selected(pin);
    open_q   = clock_open(pin);
    rise_evt = open_q &&  pin.sclk && !sclk_prev;
    fall_evt = open_q && !pin.sclk &&  sclk_prev;
  end

endmodule

// File: rtl/rct_shift_core.sv
module rct_shift_core #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         rise_evt,
  input  logic         fall_evt,
  input  logic         sdin_bit,
  input  logic         done,
  input  logic [W-1:0] result,
  output logic [W-1:0] word,
  output logic         cap,
  output logic         rd_busy,
  output logic         load_evt
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(W);

  logic [CW-1:0] cnt;

  function automatic logic [W-1:0] shift_in(logic [W-1:0] w, logic b);
    return {w[W-2:0], b};
  endfunction

  function automatic logic [CW-1:0] bump(logic [CW-1:0] c);
    return (c == CNT_TOP) ? c : c + 1'b1;
  endfunction

  always_comb begin
    rd_busy  = sel && (cnt != '0);
    load_evt = done && !rd_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (load_evt) word <= result;
    else if (fall_evt) word <= shift_in(word, cap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap <= 1'b0;
    else if (rise_evt) cap <= sdin_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!sel)                 cnt <= '0;
    else if (fall_evt && !load_evt) cnt <= bump(cnt);
  end

endmodule

// File: rtl/result_chain_tx.sv
module result_chain_tx
  import rct_pkg::*;
#(
  parameter int   WIDTH       = 18,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [WIDTH-1:0] conv_result,
  input  logic             busy,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             sclk,
  input  logic             sdin,
  output logic             sdout
);

  pins_t            pin_raw;
  pins_t            pin_q;
  logic             sel;
  logic             rise_evt;
  logic             fall_evt;
  logic [WIDTH-1:0] word;
  logic             cap;
  logic             rd_busy;
  logic             load_evt;

  assign pin_raw = '{cs_n: cs_n, rd_n: rd_n, busy: busy, sclk: sclk, sdin: sdin};

  rct_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (pin_raw),
    .synced (pin_q)
  );

  rct_edge_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (pin_q),
    .sel      (sel),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  rct_shift_core #(.W(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .sdin_bit (pin_q.sdin),
    .done     (conv_done),
    .result   (conv_result),
    .word     (word),
    .cap      (cap),
    .rd_busy  (rd_busy),
    .load_evt (load_evt)
  );

  assign sdout = sel ? word[WIDTH-1] : IDLE_LEVEL;

endmodule

// File: rtl/rct_checker.sv
module rct_checker
  import rct_pkg::*;
#(
  parameter int   W          = 18,
  parameter logic IDLE_LEVEL = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input pins_t        pin_q,
  input logic         rise_evt,
  input logic         fall_evt,
  input logic         rd_busy,
  input logic [W-1:0] word,
  input logic         cap,
  input logic         done,
  input logic [W-1:0] result,
  input logic         sdout
);

  // R2
  load_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !rd_busy |=> word == $past(result));

  // R3
  shift_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt && !(done && !rd_busy) |=> word[W-1:1] == $past(word[W-2:0]));

  // R6
  lsb_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt && !(done && !rd_busy) |=> word[0] == $past(cap));

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> cap == $past(pin_q.sdin));

  // R4
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q.cs_n || pin_q.rd_n) |-> !fall_evt && !rise_evt);

  // R5
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_q.busy |-> !fall_evt && !rise_evt);

  // R8
  read_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy && !fall_evt |=> $stable(word));

  // R7
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_q.cs_n |-> sdout == IDLE_LEVEL);

endmodule

bind result_chain_tx rct_checker #(.W(WIDTH), .IDLE_LEVEL(IDLE_LEVEL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_q    (pin_q),
  .rise_evt (rise_evt),
  .fall_evt (fall_evt),
  .rd_busy  (rd_busy),
  .word     (word),
  .cap      (cap),
  .done     (conv_done),
  .result   (conv_result),
  .sdout    (sdout)
);

// File: tb/result_chain_tx_test.sv
module result_chain_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 5;
  localparam int HALF       = 6;
  localparam int CHAIN_BITS = 2 * W + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         done = 1'b0;
  logic [W-1:0] res_dn = '0;
  logic [W-1:0] res_up = '0;
  logic         busy = 1'b0;
  logic         cs_n = 1'b1;
  logic         rd_n = 1'b1;
  logic         sclk = 1'b0;
  logic         up_sdin = 1'b0;
  logic         up_sdout;
  logic         sdout;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  result_chain_tx #(.WIDTH(W), .SYNC_STAGES(2), .IDLE_LEVEL(1'b1)) uut (
    .clk (clk), .rst_n (rst_n), .conv_done (done), .conv_result (res_dn),
    .busy (busy), .cs_n (cs_n), .rd_n (rd_n), .sclk (sclk),
    .sdin (up_sdout), .sdout (sdout));

  result_chain_tx #(.WIDTH(W), .SYNC_STAGES(2), .IDLE_LEVEL(1'b1)) uut_up (
    .clk (clk), .rst_n (rst_n), .conv_done (done), .conv_result (res_up),
    .busy (busy), .cs_n (cs_n), .rd_n (rd_n), .sclk (sclk),
    .sdin (up_sdin), .sdout (up_sdout));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [W-1:0] dn, logic [W-1:0] up);
    res_dn = dn; res_up = up; done = 1'b1;
    tick(1);
    done = 1'b0;
    tick(1);
  endtask

  task automatic pulse();
    sclk = 1'b1; tick(HALF);
    sclk = 1'b0; tick(HALF);
  endtask

  task automatic select();
    cs_n = 1'b0; rd_n = 1'b0; tick(HALF);
  endtask

  task automatic deselect();
    cs_n = 1'b1; rd_n = 1'b1; tick(HALF);
  endtask

  task automatic read_bits(int n, output logic [31:0] v);
    v = '0;
    for (int k = 0; k < n; k++) begin
      v = {v[30:0], sdout};
      pulse();
    end
  endtask

  function automatic logic [31:0] chain_exp(logic [W-1:0] dn, logic [W-1:0] up);
    return {21'd0, dn, up, 1'b0};
  endfunction

  initial begin
    logic [31:0] got;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1 / R7: reset state
    check("R7 idle after reset", 32'(sdout), 32'd1);
    select();
    check("R1 empty register", 32'(sdout), 32'd0);
    deselect();

    // R2 R3 R6: sweep all local words through full chain reads
    for (int i = 0; i < 32; i++) begin
      logic [W-1:0] up;
      up = W'((i * 7 + 3) % 32);
      load(W'(i), up);
      check("R7 idle while deselected", 32'(sdout), 32'd1);
      select();
      check("R2 R3 msb after load", 32'(sdout), 32'(i >> (W - 1)));
      read_bits(CHAIN_BITS, got);
      check("R3 R6 chain stream", got, chain_exp(W'(i), up));
      deselect();
    end

    // R7: rd_n high alone also idles
    load(5'b01010, 5'b10101);
    cs_n = 1'b0; tick(HALF);
    check("R7 idle with rd_n high", 32'(sdout), 32'd1);

    // R4: edges while not selected
    for (int k = 0; k < 3; k++) pulse();
    cs_n = 1'b1; rd_n = 1'b0; tick(HALF);
    for (int k = 0; k < 3; k++) pulse();
    select();
    read_bits(CHAIN_BITS, got);
    check("R4 gated clock ignored", got, chain_exp(5'b01010, 5'b10101));
    deselect();

    // R5: edges while busy
    load(5'b11001, 5'b00111);
    busy = 1'b1;
    select();
    for (int k = 0; k < 4; k++) pulse();
    busy = 1'b0; tick(HALF);
    read_bits(CHAIN_BITS, got);
    check("R5 busy clock ignored", got, chain_exp(5'b11001, 5'b00111));
    deselect();

    // R8: reload during a read is dropped
    load(5'b10011, 5'b01101);
    select();
    read_bits(2, got);
    load(5'b00000, 5'b11111);
    begin
      logic [31:0] rest;
      read_bits(CHAIN_BITS - 2, rest);
      got = (got << (CHAIN_BITS - 2)) | rest;
    end
    check("R8 done ignored mid-read", got, chain_exp(5'b10011, 5'b01101));
    deselect();
    load(5'b11110, 5'b00001);
    select();
    read_bits(CHAIN_BITS, got);
    check("R2 load after read ends", got, chain_exp(5'b11110, 5'b00001));
    deselect();

    // R9: clock already high at selection
    load(5'b10110, 5'b01001);
    sclk = 1'b1; tick(HALF);
    select();
    check("R9 msb with sclk high", 32'(sdout), 32'd1);
    tick(2 * HALF);
    check("R9 no shift from level", 32'(sdout), 32'd1);
    sclk = 1'b0; tick(HALF);
    check("R9 first fall shifts", 32'(sdout), 32'd0);
    pulse();
    check("R9 second bit", 32'(sdout), 32'd1);
    deselect();
    check("R7 idle at end", 32'(sdout), 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule